// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block turns a set of interrupt request wires into message writes. Each wire can be level- or edge-signalled. Every input line owns a redirection entry, split into a low and a high 32-bit word. The entry holds the following fields:

- a mask,
- the input polarity,
- the trigger mode,
- an 8-bit vector that becomes the message payload,
- a destination identifier and an extended destination identifier, which select where the message goes.

Software reaches all internal state through an indirect pair of registers. A write to the select offset chooses an internal index. The window offset then reads or writes the register at that index. A third offset accepts end-of-interrupt writes, which re-arm level-triggered lines.

Inputs pass through a two-flop synchroniser, and polarity is applied before detection.

- An edge line latches a pending bit on each asserting edge, whether or not it is masked.
- A level line requests while it is asserted and not in service.

A fixed-priority arbiter picks the lowest-numbered requesting line. The message is presented on a valid/ready port as an address/data pair and held stable until it is taken. A delivered level line stays in service until an end-of-interrupt write carries its vector. At that point it fires again if its input is still active.

Top module: `irq_msg_redirect`

## Requirements
- R1: After reset no message is offered and every entry reads back as low word 0x0001_0000 (mask set, other fields zero) and high word 0.
- R2: Internal index 0x01 is a read-only identity word: bits 7:0 hold the VERSION parameter and bits 23:16 hold NUM_LINES-1. Window writes to this index change nothing.
- R3: Register access follows these rules:
  - A bus write to offset 0x00 sets the internal index.
  - Offset 0x10 reads or writes the register at that index.
  - Line i has its low word at index 0x10+2*i and its high word at 0x11+2*i.
  - The low word stores bits 16, 15, 13, 8 and 7:0. The high word stores bits 31:16. All other bits, and every unimplemented index, read as zero.
  - Read data appears on reg_rdata in the cycle after the read strobe.
- R4: While low-word bit 16 (mask) of a line is set, that line is never granted a message.
- R5: Low-word bit 13 set makes the line active-low. A low input then counts as asserted, for both edge and level detection.
- R6: With low-word bit 15 clear (edge mode), each asserting edge sets a pending flag, even while masked. The flag is delivered as exactly one message once the line is unmasked. A held input produces no further message.
- R7: With low-word bit 15 set (level mode), an asserted, unmasked line that is not in service requests a message. Delivery marks the line in service, and no further message follows while it stays in service.
- R8: A bus write to offset 0x40 with vector V in bits 7:0 clears the in-service flag of every level line whose vector equals V. Such a line that is still asserted requests again. Lines with another vector are unaffected.
- R9: When several lines request at once, the lowest-numbered line is served first. The next line is served after the first message is taken.
- R10: Only one message is outstanding at a time. msg_addr and msg_data stay stable while msg_valid is high and msg_ready is low. msg_valid drops in the cycle after a valid&ready handshake.
- R11: msg_addr equals MSG_BASE with high-word bits 31:24 (destination ID) placed at address bits 19:12 and bits 23:16 (extended ID) placed at bits 11:4. msg_data is the 8-bit vector zero-extended to 32 bits.
- R12: Low-word bit 8 (lowest-priority mode) is stored and read back but does not change delivery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Byte offset: 0x00 select, 0x10 window, 0x40 end-of-interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| irq_in | input | NUM_LINES | Asynchronous interrupt input lines |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The block's results are due at fixed times after each stimulus:

| Stimulus | msg_valid rises |
|----------|-----------------|
| Input change on an unmasked line | After the third rising edge (two synchroniser flops, then the message register) |
| Window write that unmasks a pending line | One edge after the write |
| Matching end-of-interrupt write on a still-asserted level line | One edge after the write |
| Handshake that releases a waiting line | Delay of one more edge |
| Read strobe (reg_rdata) | One edge after the strobe |

The bench drives on falling edges and samples on falling edges. Every delivery is checked both one edge before its due cycle, expecting no message, and in the due cycle, expecting the message. This exposes an early or late output and not only a missing one.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  // bus offsets
  localparam logic [6:0] OFS_SELECT = 7'h00;
  localparam logic [6:0] OFS_WINDOW = 7'h10;
  localparam logic [6:0] OFS_EOI    = 7'h40;

  // internal indices
  localparam logic [7:0] IDX_IDENT  = 8'h01;
  localparam int         IDX_ENTRY0 = 16;

  // one redirection entry
  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic       lowpri;
    logic [7:0] vector;
    logic [7:0] dest_id;
    logic [7:0] ext_id;
  } entry_t;

  localparam entry_t ENTRY_RESET = '{mask: 1'b1, default: '0};

  function automatic logic [31:0] lo_word(entry_t e);
    logic [31:0] w;
    w        = '0;
    w[16]    = e.mask;
    w[15]    = e.level;
    w[13]    = e.act_low;
    w[8]     = e.lowpri;
    w[7:0]   = e.vector;
    return w;
  endfunction

  function automatic logic [31:0] hi_word(entry_t e);
    return {e.dest_id, e.ext_id, 16'h0000};
  endfunction

  function automatic entry_t load_lo(entry_t e, logic [31:0] w);
    entry_t r;
    r         = e;
    r.mask    = w[16];
    r.level   = w[15];
    r.act_low = w[13];
    r.lowpri  = w[8];
    r.vector  = w[7:0];
    return r;
  endfunction

  function automatic entry_t load_hi(entry_t e, logic [31:0] w);
    entry_t r;
    r         = e;
    r.dest_id = w[31:24];
    r.ext_id  = w[23:16];
    return r;
  endfunction

  // target address: base with destination fields dropped into 19:12 / 11:4
  function automatic logic [31:0] msg_address(logic [31:0] base, entry_t e);
    return base | {12'h000, e.dest_id, e.ext_id, 4'h0};
  endfunction

  function automatic logic [31:0] msg_payload(entry_t e);
    return {24'h000000, e.vector};
  endfunction

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irqr_line.sv
module irqr_line (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  input  logic       mask,
  input  logic       level,
  input  logic       act_low,
  input  logic [7:0] vector,
  input  logic       eoi_stb,
  input  logic [7:0] eoi_vec,
  input  logic       take,
  output logic       req,
  output logic       in_service,
  output logic       eoi_hit
);
  logic active;
  logic active_q;
  logic rise;
  logic pend_q;

  assign active  = sig ^ act_low;
  assign rise    = active & ~active_q;
  assign eoi_hit = eoi_stb & level & in_service & (eoi_vec == vector);

  always_comb begin
    if (level) req = ~mask & active & ~in_service;
    else       req = ~mask & (pend_q | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      in_service <= 1'b0;
    end else begin
      active_q <= active;
      if (level) pend_q <= 1'b0;
      else       pend_q <= (pend_q | rise) & ~take;
      if (take && level)  in_service <= 1'b1;
      else if (eoi_hit)   in_service <= 1'b0;
      else if (!level)    in_service <= 1'b0;
    end
  end
endmodule

// File: rtl/irqr_arbiter.sv
module irqr_arbiter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] grant,
  output logic             any
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assign grant = req & (~req + ONE);
  assign any   = |req;
endmodule

// File: rtl/irq_msg_redirect.sv
module irq_msg_redirect
  import irqr_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter logic [7:0]  VERSION   = 8'h21,
  parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [6:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam logic [7:0] TOP_IDX = 8'(NUM_LINES - 1);

  logic [7:0]           sel_q;
  entry_t               ent [NUM_LINES];
  logic [NUM_LINES-1:0] irq_sync;
  logic [NUM_LINES-1:0] req_vec;
  logic [NUM_LINES-1:0] grant_vec;
  logic [NUM_LINES-1:0] take_vec;
  logic [NUM_LINES-1:0] mask_vec;
  logic [NUM_LINES-1:0] insvc_vec;
  logic [NUM_LINES-1:0] eoi_hit_vec;
  logic                 any_req;
  logic                 win_wr;
  logic                 eoi_stb;
  logic [31:0]          win_rdata;
  entry_t               picked;

  assign win_wr  = reg_wr && (reg_addr == OFS_WINDOW);
  assign eoi_stb = reg_wr && (reg_addr == OFS_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   sel_q <= '0;
    else if (reg_wr && reg_addr == OFS_SELECT)    sel_q <= reg_wdata[7:0];
  end

  irqr_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_in),
    .q    (irq_sync)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [7:0] LO_IDX = 8'(IDX_ENTRY0 + 2 * i);
    localparam logic [7:0] HI_IDX = 8'(IDX_ENTRY0 + 2 * i + 1);
    entry_t ent_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent_q <= ENTRY_RESET;
      else if (win_wr && sel_q == LO_IDX)  ent_q <= load_lo(ent_q, reg_wdata);
      else if (win_wr && sel_q == HI_IDX)  ent_q <= load_hi(ent_q, reg_wdata);
    end

    assign ent[i]      = ent_q;
    assign mask_vec[i] = ent_q.mask;

    irqr_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig       (irq_sync[i]),
      .mask      (ent_q.mask),
      .level     (ent_q.level),
      .act_low   (ent_q.act_low),
      .vector    (ent_q.vector),
      .eoi_stb   (eoi_stb),
      .eoi_vec   (reg_wdata[7:0]),
      .take      (take_vec[i]),
      .req       (req_vec[i]),
      .in_service(insvc_vec[i]),
      .eoi_hit   (eoi_hit_vec[i])
    );
  end

  irqr_arbiter #(.WIDTH(NUM_LINES)) u_arb (
    .req  (req_vec),
    .grant(grant_vec),
    .any  (any_req)
  );

  assign take_vec = msg_valid ? '0 : grant_vec;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (grant_vec[i]) picked = entry_t'(picked | ent[i]);
  end

  always_comb begin
    win_rdata = '0;
    if (sel_q == IDX_IDENT) win_rdata = {8'h00, TOP_IDX, 8'h00, VERSION};
    for (int i = 0; i < NUM_LINES; i++) begin
      if (sel_q == 8'(IDX_ENTRY0 + 2 * i))     win_rdata = lo_word(ent[i]);
      if (sel_q == 8'(IDX_ENTRY0 + 2 * i + 1)) win_rdata = hi_word(ent[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_SELECT: reg_rdata <= {24'h0, sel_q};
        OFS_WINDOW: reg_rdata <= win_rdata;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any_req) begin
      msg_valid <= 1'b1;
      msg_addr  <= msg_address(MSG_BASE, picked);
      msg_data  <= msg_payload(picked);
    end
  end
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [31:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NUM_LINES-1:0] req_vec,
  input logic [NUM_LINES-1:0] take_vec,
  input logic [NUM_LINES-1:0] mask_vec,
  input logic [NUM_LINES-1:0] insvc_vec,
  input logic [NUM_LINES-1:0] eoi_hit_vec
);
  localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  p_busy_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> take_vec == '0);

  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_vec != '0 |-> ((take_vec - ONE) & req_vec) == '0);

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & mask_vec) == '0);

  p_payload_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:8] == 24'h0);

  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit_vec & ~take_vec) != '0 |=> (insvc_vec & $past(eoi_hit_vec & ~take_vec)) == '0);

  p_take_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & insvc_vec) == '0);
endmodule

bind irq_msg_redirect irqr_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .req_vec    (req_vec),
  .take_vec   (take_vec),
  .mask_vec   (mask_vec),
  .insvc_vec  (insvc_vec),
  .eoi_hit_vec(eoi_hit_vec)
);

// File: tb/sim_irq_msg_redirect.sv
module sim_irq_msg_redirect;
  localparam int          N    = 8;
  localparam logic [31:0] BASE = 32'hFEE0_0000;
  localparam logic [7:0]  VER  = 8'h21;

  typedef struct packed {
    logic [2:0] line;
    logic       pol;
    logic       lvl;
    logic [7:0] vec;
    logic [7:0] dest;
    logic [7:0] ext;
  } row_t;

  localparam row_t TBL [6] = '{
    '{3'd0, 1'b0, 1'b0, 8'h31, 8'h01, 8'h00},
    '{3'd1, 1'b1, 1'b0, 8'h52, 8'hA5, 8'h3C},
    '{3'd3, 1'b0, 1'b1, 8'h77, 8'h10, 8'hFF},
    '{3'd4, 1'b1, 1'b1, 8'h80, 8'hFF, 8'h01},
    '{3'd6, 1'b0, 1'b0, 8'hFE, 8'h00, 8'h7E},
    '{3'd7, 1'b1, 1'b1, 8'h09, 8'h5A, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_msg_redirect #(.NUM_LINES(N), .VERSION(VER), .MSG_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [6:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic win_wr(logic [7:0] idx, logic [31:0] d);
    bus_wr(7'h00, {24'h0, idx});
    bus_wr(7'h10, d);
  endtask

  task automatic win_rd(logic [7:0] idx, output logic [31:0] d);
    bus_wr(7'h00, {24'h0, idx});
    reg_addr = 7'h10; reg_rd = 1'b1;
    cyc(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    cyc(1);
    msg_ready = 1'b0;
  endtask

  function automatic logic [31:0] lo_w(bit pol, bit lvl, bit msk, bit lp, logic [7:0] v);
    return (32'(msk) << 16) | (32'(lvl) << 15) | (32'(pol) << 13) | (32'(lp) << 8) | 32'(v);
  endfunction

  function automatic logic [31:0] exp_addr(logic [7:0] dest, logic [7:0] ext);
    return BASE + 32'(dest) * 32'd4096 + 32'(ext) * 32'd16;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    string       tag;
    row_t        e;

    cyc(3);
    check("R1 no message in reset", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    cyc(2);

    // reset contents and identity word
    win_rd(8'h10, rd); check("R1 line0 low after reset", rd, 32'h0001_0000);
    win_rd(8'h11, rd); check("R1 line0 high after reset", rd, 32'h0);
    win_rd(8'h1E, rd); check("R1 line7 low after reset", rd, 32'h0001_0000);
    win_rd(8'h01, rd); check("R2 identity word", rd, {8'h00, 8'(N-1), 8'h00, VER});
    win_wr(8'h01, 32'h0);
    win_rd(8'h01, rd); check("R2 identity read-only", rd, {8'h00, 8'(N-1), 8'h00, VER});
    win_rd(8'h20, rd); check("R3 unimplemented index", rd, 32'h0);
    win_rd(8'h00, rd); check("R3 index zero", rd, 32'h0);

    // field storage on line 3
    win_wr(8'h16, 32'hFFFF_FFFF);
    win_rd(8'h16, rd); check("R3 low word stored bits", rd, 32'h0001_A1FF);
    win_wr(8'h17, 32'hFFFF_FFFF);
    win_rd(8'h17, rd); check("R3 high word stored bits", rd, 32'hFFFF_0000);
    check("R4 masked level line silent", 32'(msg_valid), 32'd0);
    win_wr(8'h16, 32'h0001_0000);
    win_wr(8'h17, 32'h0);

    // table walk
    for (int k = 0; k < 6; k++) begin
      e = TBL[k];
      tag = e.pol ? "R5" : (e.lvl ? "R7" : "R6");
      if (e.pol) begin
        win_wr(8'(16 + 2 * e.line), lo_w(1'b1, 1'b1, 1'b1, 1'b0, 8'h00));
        irq_in[e.line] = 1'b1;
        cyc(4);
      end
      win_wr(8'(17 + 2 * e.line), {e.dest, e.ext, 16'h0});
      win_wr(8'(16 + 2 * e.line), lo_w(e.pol, e.lvl, 1'b0, 1'b0, e.vec));
      cyc(2);
      check({tag, " idle before assert"}, 32'(msg_valid), 32'd0);
      irq_in[e.line] = ~e.pol;
      cyc(2);
      check({tag, " not yet after 2 edges"}, 32'(msg_valid), 32'd0);
      cyc(1);
      check({tag, " message after 3 edges"}, 32'(msg_valid), 32'd1);
      check("R11 address", msg_addr, exp_addr(e.dest, e.ext));
      check("R11 data", msg_data, 32'(e.vec));
      accept();
      check("R10 valid drops after handshake", 32'(msg_valid), 32'd0);
      if (e.lvl) begin
        cyc(4);
        check("R7 in service holds off", 32'(msg_valid), 32'd0);
        irq_in[e.line] = e.pol;
        cyc(3);
        bus_wr(7'h40, {24'h0, e.vec});
        cyc(3);
        check("R8 released line deasserted", 32'(msg_valid), 32'd0);
      end else begin
        cyc(4);
        check("R6 one message per edge", 32'(msg_valid), 32'd0);
        irq_in[e.line] = e.pol;
        cyc(3);
      end
      win_wr(8'(16 + 2 * e.line), lo_w(e.pol, e.lvl, 1'b1, 1'b0, e.vec));
    end

    // R6: masked edge latched, delivered on unmask (line 2)
    win_wr(8'h15, 32'h2244_0000);
    irq_in[2] = 1'b1; cyc(2); irq_in[2] = 1'b0;
    cyc(5);
    check("R6 masked edge not delivered", 32'(msg_valid), 32'd0);
    win_wr(8'h14, lo_w(1'b0, 1'b0, 1'b0, 1'b0, 8'h42));
    check("R6 one edge after unmask", 32'(msg_valid), 32'd0);
    cyc(1);
    check("R6 pending edge delivered", 32'(msg_valid), 32'd1);
    check("R6 pending edge data", msg_data, 32'h42);
    accept();
    cyc(4);
    check("R6 no repeat of latched edge", 32'(msg_valid), 32'd0);

    // R4 / R12 / R7 / R8 on line 5 (level)
    win_wr(8'h1B, 32'h030C_0000);
    win_wr(8'h1A, lo_w(1'b0, 1'b1, 1'b1, 1'b0, 8'h66));
    irq_in[5] = 1'b1;
    cyc(6);
    check("R4 masked asserted level", 32'(msg_valid), 32'd0);
    win_wr(8'h1A, lo_w(1'b0, 1'b1, 1'b0, 1'b1, 8'h66));
    cyc(1);
    check("R12 delivery with bit 8 set", 32'(msg_valid), 32'd1);
    check("R12 address unchanged by bit 8", msg_addr, exp_addr(8'h03, 8'h0C));
    check("R12 data unchanged by bit 8", msg_data, 32'h66);
    accept();
    win_rd(8'h1A, rd); check("R12 bit 8 read back", rd, 32'h0000_8166);
    cyc(2);
    check("R7 held while in service", 32'(msg_valid), 32'd0);
    bus_wr(7'h40, 32'h65);
    cyc(3);
    check("R8 other vector ignored", 32'(msg_valid), 32'd0);
    bus_wr(7'h40, 32'h66);
    check("R8 not before one edge", 32'(msg_valid), 32'd0);
    cyc(1);
    check("R8 refire while asserted", 32'(msg_valid), 32'd1);
    check("R8 refire data", msg_data, 32'h66);
    accept();
    irq_in[5] = 1'b0;
    cyc(3);
    bus_wr(7'h40, 32'h66);
    cyc(4);
    check("R8 no refire when deasserted", 32'(msg_valid), 32'd0);

    // R9 / R10 priority and hold, lines 2 and 5 as edge
    win_wr(8'h1A, lo_w(1'b0, 1'b0, 1'b0, 1'b0, 8'h66));
    cyc(2);
    irq_in[2] = 1'b1; irq_in[5] = 1'b1;
    cyc(3);
    check("R9 lowest line first", msg_data, 32'h42);
    check("R9 first valid", 32'(msg_valid), 32'd1);
    cyc(3);
    check("R10 data held", msg_data, 32'h42);
    check("R10 address held", msg_addr, exp_addr(8'h22, 8'h44));
    accept();
    check("R10 gap after handshake", 32'(msg_valid), 32'd0);
    cyc(1);
    check("R9 second line served", msg_data, 32'h66);
    check("R9 second address", msg_addr, exp_addr(8'h03, 8'h0C));
    accept();
    cyc(4);
    check("R6 held edges give no more", 32'(msg_valid), 32'd0);
    irq_in[2] = 1'b0; irq_in[5] = 1'b0;
    cyc(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule